// File: doc/BRIEF.md
# Single-Axis Polyphase Line Resizer with Color Conversion and Write Mask

The block resamples one line of image samples along a single axis. A line of YUV triples is first captured into an internal line store. The block then walks a fixed-point source position across that line, one output pixel at a time. For each output it runs a five-tap filter whose coefficients are picked from one of sixteen phase sets. The phase comes from the fractional part of the position, and the filter centre comes from the integer part. Resizing in both axes takes two passes, with the frame transposed between them by whatever feeds the block.

Each filtered pixel may then pass through a programmable 3x3 color matrix with per-channel offsets, which turns YUV into RGB. Last of all the pixel is tagged with a write enable taken from a per-pixel occlusion mask indexed by its output column. The pixel stream therefore always covers every destination column, while only the visible pixels are marked for writing. This lets the output be dropped into a window that other windows partly cover.

Top module: `poly_resizer`

## Requirements
- R1: After `start` is seen while the block is idle, the first `cfg_in_len` cycles with `in_valid` high load input samples 0,1,2,... of the line. `in_valid` at any other time has no effect on the outputs.
- R2: Each pass emits exactly `cfg_out_len` pixels with `out_valid` high. `out_x` counts 0,1,2,... in order, and `out_last` is high only together with the final pixel.
- R3: Output pixel k uses source position P = k*`cfg_step`, a number with 12 fraction bits. Its filter centre is input sample P>>12, and its coefficient phase is bits [11:8] of P.
- R4: Each channel is computed as sum over taps t=0..4 of coef[phase][t]*sample[centre+t-2], where tap 0 is the leftmost. Coefficients are signed with 8 fraction bits. The sum gets 128 added, is shifted right arithmetically by 8, and is clamped to 0..255.
- R5: Tap indices below 0 read sample 0, and indices above `cfg_in_len`-1 read the last loaded sample.
- R6: A cycle with `coef_we` high writes `coef_data` to the entry selected by `coef_phase` and `coef_tap`. A write with `coef_tap` above 4 changes nothing.
- R7: With `cfg_csc_en` low the filtered triple is output unchanged. Y sits in bits [23:16], U in [15:8] and V in [7:0].
- R8: With `cfg_csc_en` high, output row r (R in bits [23:16], G in [15:8], B in [7:0]) is ((M[r][0]*Y + M[r][1]*U + M[r][2]*V + 128) >>> 8) + off[r], saturated to 0..255. M[r][j] is the 12-bit signed field at `cfg_mat` bits [(3r+j)*12 +: 12], and off[r] is the 10-bit signed field at `cfg_off` bits [r*10 +: 10].
- R9: `out_wen` equals `cfg_mask[out_x]` on every output pixel. A pixel whose mask bit is 0 is still emitted and still counted.
- R10: A `start` pulse while a line is being loaded or filtered is ignored.
- R11: After reset the outputs are low, and every phase holds the identity kernel (256 on tap 2, 0 elsewhere).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (honoured only when idle) |
| cfg_in_len | input | 7 | Input samples in the line, 1..64 |
| cfg_out_len | input | 7 | Output pixels to produce, 1..64 |
| cfg_step | input | 19 | Source advance per output pixel, 12 fraction bits |
| cfg_csc_en | input | 1 | Enable YUV-to-RGB matrix |
| cfg_mat | input | 108 | Nine signed matrix entries, 8 fraction bits |
| cfg_off | input | 30 | Three signed output offsets |
| cfg_mask | input | 64 | Occlusion bit per output column |
| coef_we | input | 1 | Coefficient write strobe |
| coef_phase | input | 4 | Phase set written |
| coef_tap | input | 3 | Tap written |
| coef_data | input | 10 | Signed coefficient value |
| in_valid | input | 1 | Input sample present |
| in_pix | input | 24 | Input YUV triple |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 24 | Output pixel (YUV or RGB) |
| out_wen | output | 1 | Write enable from the mask |
| out_x | output | 6 | Destination column |
| out_last | output | 1 | Final pixel of the pass |

## Verification
The embedded properties rely on the line length, output length, step and mask staying constant from `start` until the final pixel leaves. They also rely on both lengths lying in 1..64. Each directed pass in the bench programs its settings while the block is idle and leaves them alone until the pass has drained. Only stray `start` and `in_valid` pulses are injected mid-pass, and those are the inputs the block is required to ignore.

// File: rtl/rsz_pkg.sv
// Shared constants and types for the single-axis resizer.
// Assumes three 8-bit channels per pixel and a five-tap, sixteen-phase filter.
package rsz_pkg;
    localparam int TAPS   = 5;
    localparam int TAP_W  = $clog2(TAPS);
    localparam int PHASES = 16;
    localparam int PH_W   = $clog2(PHASES);
    localparam int PIX_W  = 8;
    localparam int NCH    = 3;
    localparam int CFRAC  = 8;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_LOAD = 2'd1,
        RS_RUN  = 2'd2
    } rsz_state_e;
endpackage

// File: rtl/rsz_line_buf.sv
// Line store: one write port for capture, one combinational read port for taps.
// Assumes DEPTH is a power of two; entries are not reset because reads only
// ever reach locations written during the current load.
module rsz_line_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // capture one sample per accepted input cycle
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rsz_fir_core.sv
// Serial five-tap polyphase filter: one tap per cycle, three channels in
// parallel, coefficient table held in registers and reset to identity.
// Assumes taps arrive in order 0..TAPS-1 on consecutive cycles.
module rsz_fir_core
    import rsz_pkg::*;
#(
    parameter int COEF_W = 10,
    localparam int PXW   = NCH * PIX_W,
    localparam int ACC_W = PIX_W + COEF_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_we,
    input  logic [PH_W-1:0]   cw_phase,
    input  logic [TAP_W-1:0]  cw_tap,
    input  logic [COEF_W-1:0] cw_data,
    input  logic              tap_vld,
    input  logic [TAP_W-1:0]  tap_idx,
    input  logic [PH_W-1:0]   phase,
    input  logic [PXW-1:0]    smp,
    output logic              fir_vld,
    output logic [PXW-1:0]    fir_pix
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (CFRAC - 1);
    localparam logic signed [ACC_W-1:0] PMAX = ACC_W'((1 << PIX_W) - 1);
    localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1 << CFRAC);

    logic signed [COEF_W-1:0] ctab [PHASES][TAPS];
    logic signed [COEF_W-1:0] cur;
    logic signed [ACC_W-1:0]  cext;
    logic [PXW-1:0]           res_flat;
    logic                     first_tap;
    logic                     last_tap;

    assign first_tap = (tap_idx == '0);
    assign last_tap  = (tap_idx == TAP_W'(TAPS - 1));

    // coefficient table: identity after reset, then written per entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PHASES; p++)
                for (int t = 0; t < TAPS; t++)
                    ctab[p][t] <= (t == TAPS / 2) ? UNITY : '0;
        end else if (cw_we && (cw_tap < TAP_W'(TAPS))) begin
            ctab[cw_phase][cw_tap] <= cw_data;
        end
    end

    assign cur  = ctab[phase][tap_idx];
    assign cext = {{(ACC_W - COEF_W){cur[COEF_W-1]}}, cur};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] sext;
        logic signed [ACC_W-1:0] prod;
        logic signed [ACC_W-1:0] total;
        logic signed [ACC_W-1:0] rnd;

        assign sext  = {{(ACC_W - PIX_W){1'b0}}, smp[c*PIX_W +: PIX_W]};
        assign prod  = sext * cext;
        assign total = first_tap ? prod : (acc_q + prod);
        assign rnd   = (total + HALF) >>> CFRAC;

        // running sum across the taps of one output pixel
        always_ff @(posedge clk) begin
            if (!rst_n)       acc_q <= '0;
            else if (tap_vld) acc_q <= total;
        end

        // round and clamp the finished sum into pixel range
        always_comb begin
            if (rnd[ACC_W-1])    res_flat[c*PIX_W +: PIX_W] = '0;
            else if (rnd > PMAX) res_flat[c*PIX_W +: PIX_W] = '1;
            else                 res_flat[c*PIX_W +: PIX_W] = rnd[PIX_W-1:0];
        end
    end

    // register the filtered pixel when the last tap completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fir_vld <= 1'b0;
            fir_pix <= '0;
        end else begin
            fir_vld <= tap_vld && last_tap;
            if (tap_vld && last_tap) fir_pix <= res_flat;
        end
    end

    // R2: a result takes five tap cycles, so two results never touch
    p_fir_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fir_vld |=> !fir_vld);
endmodule

// File: rtl/rsz_csc.sv
// Output stage: optional 3x3 matrix with offsets (YUV in, RGB out), then
// tags the pixel with its occlusion bit. One register stage.
// Assumes matrix entries carry 8 fraction bits and OUT_MAX is a power of two.
module rsz_csc
    import rsz_pkg::*;
#(
    parameter int MAT_W   = 12,
    parameter int OFF_W   = 10,
    parameter int OUT_MAX = 64,
    localparam int XW     = $clog2(OUT_MAX),
    localparam int PXW    = NCH * PIX_W,
    localparam int SUM_W  = PIX_W + MAT_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [PXW-1:0]           in_pix,
    input  logic [XW-1:0]            in_x,
    input  logic                     in_last,
    input  logic                     en,
    input  logic [NCH*NCH*MAT_W-1:0] mat,
    input  logic [NCH*OFF_W-1:0]     off,
    input  logic [OUT_MAX-1:0]       mask,
    output logic                     out_vld,
    output logic [PXW-1:0]           out_pix,
    output logic                     out_wen,
    output logic [XW-1:0]            out_x,
    output logic                     out_last
);
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (CFRAC - 1);
    localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << PIX_W) - 1);

    logic [PXW-1:0] conv;

    for (genvar r = 0; r < NCH; r++) begin : g_row
        logic signed [SUM_W-1:0] sum;
        logic signed [SUM_W-1:0] rnd;
        logic signed [SUM_W-1:0] offx;
        logic signed [SUM_W-1:0] tot;
        logic [OFF_W-1:0]        ofv;

        // dot product of one matrix row with the Y,U,V components
        always_comb begin
            sum = '0;
            for (int j = 0; j < NCH; j++) begin
                logic [MAT_W-1:0]        m;
                logic signed [SUM_W-1:0] mx;
                logic signed [SUM_W-1:0] px;
                m   = mat[(r*NCH + j)*MAT_W +: MAT_W];
                mx  = {{(SUM_W - MAT_W){m[MAT_W-1]}}, m};
                px  = {{(SUM_W - PIX_W){1'b0}}, in_pix[(NCH-1-j)*PIX_W +: PIX_W]};
                sum = sum + mx * px;
            end
        end

        assign ofv  = off[r*OFF_W +: OFF_W];
        assign offx = {{(SUM_W - OFF_W){ofv[OFF_W-1]}}, ofv};
        assign rnd  = (sum + HALF) >>> CFRAC;
        assign tot  = rnd + offx;

        // saturate the row result, or pass the component through when disabled
        always_comb begin
            if (!en)             conv[(NCH-1-r)*PIX_W +: PIX_W] = in_pix[(NCH-1-r)*PIX_W +: PIX_W];
            else if (tot[SUM_W-1]) conv[(NCH-1-r)*PIX_W +: PIX_W] = '0;
            else if (tot > PMAX) conv[(NCH-1-r)*PIX_W +: PIX_W] = '1;
            else                 conv[(NCH-1-r)*PIX_W +: PIX_W] = tot[PIX_W-1:0];
        end
    end

    // output register with mask lookup by destination column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_pix  <= '0;
            out_wen  <= 1'b0;
            out_x    <= '0;
            out_last <= 1'b0;
        end else begin
            out_vld  <= in_vld;
            out_wen  <= in_vld && mask[in_x];
            out_last <= in_vld && in_last;
            if (in_vld) begin
                out_pix <= conv;
                out_x   <= in_x;
            end
        end
    end

    // R9: a write enable only ever accompanies an emitted pixel
    p_wen_with_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> out_vld);
    // R2: the end marker only ever accompanies an emitted pixel
    p_last_with_pixel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_vld);
endmodule

// File: rtl/poly_resizer.sv
// Top: loads a line, steps a fixed-point source position once per output
// pixel, clamps tap addresses to the line ends and drives the filter and
// output stage. Assumes configuration is held steady for a whole pass.
module poly_resizer
    import rsz_pkg::*;
#(
    parameter int LINE_MAX = 64,
    parameter int OUT_MAX  = 64,
    parameter int COEF_W   = 10,
    parameter int MAT_W    = 12,
    parameter int OFF_W    = 10,
    parameter int FRAC     = 12,
    localparam int AW      = $clog2(LINE_MAX),
    localparam int LENW    = AW + 1,
    localparam int XW      = $clog2(OUT_MAX),
    localparam int OLENW   = XW + 1,
    localparam int SW      = LENW + FRAC,
    localparam int PXW     = NCH * PIX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [LENW-1:0]          cfg_in_len,
    input  logic [OLENW-1:0]         cfg_out_len,
    input  logic [SW-1:0]            cfg_step,
    input  logic                     cfg_csc_en,
    input  logic [NCH*NCH*MAT_W-1:0] cfg_mat,
    input  logic [NCH*OFF_W-1:0]     cfg_off,
    input  logic [OUT_MAX-1:0]       cfg_mask,
    input  logic                     coef_we,
    input  logic [PH_W-1:0]          coef_phase,
    input  logic [TAP_W-1:0]         coef_tap,
    input  logic [COEF_W-1:0]        coef_data,
    input  logic                     in_valid,
    input  logic [PXW-1:0]           in_pix,
    output logic                     out_valid,
    output logic [PXW-1:0]           out_pix,
    output logic                     out_wen,
    output logic [XW-1:0]            out_x,
    output logic                     out_last
);
    localparam int POSW = SW + XW;
    localparam int CTRW = POSW - FRAC;
    localparam int IDXW = CTRW + 2;
    localparam logic signed [IDXW-1:0] HALF_WIN = IDXW'(TAPS / 2);

    rsz_state_e              state;
    logic [AW-1:0]           wr_cnt;
    logic [POSW-1:0]         pos;
    logic [TAP_W-1:0]        tap;
    logic [XW-1:0]           k;
    logic [XW-1:0]           x_q;
    logic                    last_q;
    logic [LENW-1:0]         in_hi;
    logic [OLENW-1:0]        out_hi;
    logic [CTRW-1:0]         centre;
    logic [PH_W-1:0]         phase;
    logic [FRAC-PH_W-1:0]    unused_frac;
    logic signed [IDXW-1:0]  idx_s;
    logic signed [IDXW-1:0]  hi_s;
    logic [AW-1:0]           rd_addr;
    logic [PXW-1:0]          rd_pix;
    logic                    tap_vld;
    logic                    buf_we;
    logic                    fir_vld;
    logic [PXW-1:0]          fir_pix;

    assign in_hi       = cfg_in_len - LENW'(1);
    assign out_hi      = cfg_out_len - OLENW'(1);
    assign centre      = pos[POSW-1:FRAC];
    assign phase       = pos[FRAC-1 -: PH_W];
    assign unused_frac = pos[FRAC-PH_W-1:0];
    assign tap_vld     = (state == RS_RUN);
    assign buf_we      = (state == RS_LOAD) && in_valid;

    // tap address relative to the filter centre, clamped to the loaded line
    assign idx_s = $signed({2'b00, centre}) + $signed({{(IDXW - TAP_W){1'b0}}, tap}) - HALF_WIN;
    assign hi_s  = $signed({{(IDXW - LENW){1'b0}}, in_hi});
    always_comb begin
        if (idx_s[IDXW-1])     rd_addr = '0;
        else if (idx_s > hi_s) rd_addr = in_hi[AW-1:0];
        else                   rd_addr = idx_s[AW-1:0];
    end

    // pass sequencer: idle, capture the line, then five tap cycles per output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RS_IDLE;
            wr_cnt <= '0;
            pos    <= '0;
            tap    <= '0;
            k      <= '0;
        end else begin
            case (state)
                RS_IDLE: begin
                    if (start) begin
                        state  <= RS_LOAD;
                        wr_cnt <= '0;
                    end
                end
                RS_LOAD: begin
                    if (in_valid) begin
                        wr_cnt <= wr_cnt + 1'b1;
                        if ({1'b0, wr_cnt} == in_hi) begin
                            state <= RS_RUN;
                            pos   <= '0;
                            tap   <= '0;
                            k     <= '0;
                        end
                    end
                end
                RS_RUN: begin
                    if (tap == TAP_W'(TAPS - 1)) begin
                        tap <= '0;
                        pos <= pos + {{XW{1'b0}}, cfg_step};
                        k   <= k + 1'b1;
                        if ({1'b0, k} == out_hi) state <= RS_IDLE;
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    // carry column and end marker alongside the filter result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            last_q <= 1'b0;
        end else if (tap_vld && (tap == TAP_W'(TAPS - 1))) begin
            x_q    <= k;
            last_q <= ({1'b0, k} == out_hi);
        end
    end

    rsz_line_buf #(
        .DEPTH (LINE_MAX),
        .DW    (PXW)
    ) u_line (
        .clk   (clk),
        .we    (buf_we),
        .waddr (wr_cnt),
        .wdata (in_pix),
        .raddr (rd_addr),
        .rdata (rd_pix)
    );

    rsz_fir_core #(
        .COEF_W (COEF_W)
    ) u_fir (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_we    (coef_we),
        .cw_phase (coef_phase),
        .cw_tap   (coef_tap),
        .cw_data  (coef_data),
        .tap_vld  (tap_vld),
        .tap_idx  (tap),
        .phase    (phase),
        .smp      (rd_pix),
        .fir_vld  (fir_vld),
        .fir_pix  (fir_pix)
    );

    rsz_csc #(
        .MAT_W   (MAT_W),
        .OFF_W   (OFF_W),
        .OUT_MAX (OUT_MAX)
    ) u_csc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (fir_vld),
        .in_pix   (fir_pix),
        .in_x     (x_q),
        .in_last  (last_q),
        .en       (cfg_csc_en),
        .mat      (cfg_mat),
        .off      (cfg_off),
        .mask     (cfg_mask),
        .out_vld  (out_valid),
        .out_pix  (out_pix),
        .out_wen  (out_wen),
        .out_x    (out_x),
        .out_last (out_last)
    );

    // R5: every tap read while filtering lands inside the loaded line
    p_tap_in_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_RUN) |-> ({1'b0, rd_addr} < cfg_in_len));
    // R1: capture never runs past the programmed line length
    p_load_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_LOAD) |-> ({1'b0, wr_cnt} < cfg_in_len));
    // R2: every emitted column lies inside the programmed output length
    p_col_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_x} < cfg_out_len));
endmodule

// File: tb/tb_poly_resizer.sv
// Directed bench: one task per scenario, each computing its own expected
// pixels from the requirements and comparing them against the stream.
module tb_poly_resizer;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [6:0]    cfg_in_len = 7'd1;
    logic [6:0]    cfg_out_len = 7'd1;
    logic [18:0]   cfg_step = 19'd4096;
    logic          cfg_csc_en = 1'b0;
    logic [107:0]  cfg_mat = '0;
    logic [29:0]   cfg_off = '0;
    logic [63:0]   cfg_mask = '1;
    logic          coef_we = 1'b0;
    logic [3:0]    coef_phase = '0;
    logic [2:0]    coef_tap = '0;
    logic [9:0]    coef_data = '0;
    logic          in_valid = 1'b0;
    logic [23:0]   in_pix = '0;
    logic          out_valid;
    logic [23:0]   out_pix;
    logic          out_wen;
    logic [5:0]    out_x;
    logic          out_last;

    int checks = 0;
    int fails  = 0;
    int smp [64][3];
    int tcoef [16][5];
    int tmat [3][3];
    int toff [3];
    logic [23:0] got_pix [64];
    logic        got_wen [64];
    int          got_x [64];
    logic        got_last [64];
    int  ocnt = 0;
    bit  last_seen = 0;

    always #5 clk = ~clk;

    poly_resizer dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_in_len(cfg_in_len), .cfg_out_len(cfg_out_len), .cfg_step(cfg_step),
        .cfg_csc_en(cfg_csc_en), .cfg_mat(cfg_mat), .cfg_off(cfg_off), .cfg_mask(cfg_mask),
        .coef_we(coef_we), .coef_phase(coef_phase), .coef_tap(coef_tap), .coef_data(coef_data),
        .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix), .out_wen(out_wen),
        .out_x(out_x), .out_last(out_last)
    );

    // collect every emitted pixel away from the active edge
    always @(negedge clk) begin
        if (out_valid) begin
            if (ocnt < 64) begin
                got_pix[ocnt]  = out_pix;
                got_wen[ocnt]  = out_wen;
                got_x[ocnt]    = int'(out_x);
                got_last[ocnt] = out_last;
            end
            if (out_last) last_seen = 1;
            ocnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sat8(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int fir_exp(input int k, input int ch, input int inl, input int step);
        int pos = k * step;
        int ctr = pos >>> 12;
        int ph  = (pos >>> 8) & 15;
        int s   = 0;
        for (int t = 0; t < 5; t++) begin
            int idx = ctr + t - 2;
            if (idx < 0) idx = 0;
            if (idx > inl - 1) idx = inl - 1;
            s += tcoef[ph][t] * smp[idx][ch];
        end
        return sat8((s + 128) >>> 8);
    endfunction

    function automatic logic [23:0] pix_exp(input int k, input int inl, input int step, input bit csc);
        int f [3];
        int o [3];
        for (int c = 0; c < 3; c++) f[c] = fir_exp(k, c, inl, step);
        for (int r = 0; r < 3; r++) begin
            if (csc) o[r] = sat8(((tmat[r][0]*f[0] + tmat[r][1]*f[1] + tmat[r][2]*f[2] + 128) >>> 8) + toff[r]);
            else     o[r] = f[r];
        end
        return {8'(o[0]), 8'(o[1]), 8'(o[2])};
    endfunction

    task automatic write_coef(input int ph, input int tp, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_phase = 4'(ph); coef_tap = 3'(tp); coef_data = 10'(val);
        @(negedge clk);
        coef_we = 1'b0;
        if (tp < 5) tcoef[ph][tp] = val;
    endtask

    task automatic set_kernel(input int kind);
        for (int p = 0; p < 16; p++) begin
            for (int t = 0; t < 5; t++) begin
                int v;
                if (kind == 0) v = (t == 0 || t == 4) ? -40 + p : (t == 2) ? 380 - 2*p : -40;
                else           v = (t == 2) ? 96 : (t == 1 || t == 3) ? 64 : 16;
                write_coef(p, t, v);
            end
        end
    endtask

    task automatic fill(input int seed, input int kind);
        for (int i = 0; i < 64; i++) begin
            if (kind == 0) smp[i][0] = (i*37 + seed*13) % 256;
            else           smp[i][0] = (i % 2 == 1) ? 250 : 5;
            smp[i][1] = (i*29 + seed*71 + 7) % 256;
            smp[i][2] = (i*53 + seed*5 + 100) % 256;
        end
    endtask

    task automatic set_csc();
        tmat[0][0] = 256; tmat[0][1] = 0;    tmat[0][2] = 359;  toff[0] = -179;
        tmat[1][0] = 256; tmat[1][1] = -88;  tmat[1][2] = -183; toff[1] = 135;
        tmat[2][0] = 256; tmat[2][1] = 454;  tmat[2][2] = 0;    toff[2] = -227;
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 3; j++) cfg_mat[(r*3 + j)*12 +: 12] = 12'(tmat[r][j]);
            cfg_off[r*10 +: 10] = 10'(toff[r]);
        end
    endtask

    // run one pass, optionally injecting stray start/in_valid mid-pass, and check it
    task automatic do_pass(input int inl, input int outl, input int step, input bit csc,
                           input logic [63:0] mask, input bit noise, input string req);
        @(negedge clk);
        cfg_in_len = 7'(inl); cfg_out_len = 7'(outl); cfg_step = 19'(step);
        cfg_csc_en = csc; cfg_mask = mask;
        ocnt = 0; last_seen = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < inl; i++) begin
            if (i % 4 == 3) begin in_valid = 1'b0; @(negedge clk); end
            in_valid = 1'b1;
            in_pix = {8'(smp[i][0]), 8'(smp[i][1]), 8'(smp[i][2])};
            @(negedge clk);
        end
        in_valid = 1'b0;
        if (noise) begin
            start = 1'b1; in_valid = 1'b1; in_pix = 24'hA5A5A5;
            repeat (3) @(negedge clk);
            start = 1'b0; in_valid = 1'b0;
        end
        while (!last_seen) @(negedge clk);
        repeat (12) @(negedge clk);
        check(ocnt == outl, {req, " R2 count"}, ocnt, outl);
        for (int k = 0; k < outl && k < 64; k++) begin
            logic [23:0] e;
            e = pix_exp(k, inl, step, csc);
            check(got_pix[k] == e, {req, " pixel"}, int'(got_pix[k]), int'(e));
            check(got_x[k] == k, "R2 column", got_x[k], k);
            check(got_wen[k] == mask[k], "R9 write enable", int'(got_wen[k]), int'(mask[k]));
            check(got_last[k] == (k == outl - 1), "R2 last flag", int'(got_last[k]), int'(k == outl - 1));
        end
    endtask

    task automatic t_reset();
        for (int p = 0; p < 16; p++)
            for (int t = 0; t < 5; t++) tcoef[p][t] = (t == 2) ? 256 : 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
        check(out_wen == 1'b0, "R11 out_wen", int'(out_wen), 0);
        check(out_last == 1'b0, "R11 out_last", int'(out_last), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_identity();   // R11 identity kernel, R7 passthrough, R3 unit step
        fill(1, 0);
        do_pass(8, 8, 4096, 1'b0, '1, 1'b0, "R11 R7 R3");
    endtask

    task automatic t_downscale();  // R6 coefficient load, R4 clamp, R5 right edge
        set_kernel(0);
        write_coef(3, 5, 511);     // R6: tap index 5 must not land anywhere
        fill(2, 1);
        do_pass(20, 13, 6144, 1'b0, '1, 1'b0, "R6 R4 R5");
    endtask

    task automatic t_upscale();    // R3 fractional phases, R5 edges, R9 mask
        fill(3, 0);
        do_pass(10, 20, 2048, 1'b0, 64'h5555_5555_5555_5555, 1'b0, "R3 R5 R9");
    endtask

    task automatic t_color();      // R8 matrix with saturation
        set_kernel(1);
        set_csc();
        fill(4, 0);
        do_pass(16, 20, 3000, 1'b1, '1, 1'b0, "R8");
    endtask

    task automatic t_stray();      // R1 stray samples, R10 stray start, R9 mask
        fill(5, 0);
        do_pass(30, 24, 4608, 1'b1, 64'hF0F0_3C3C_A5A5_0FF1, 1'b1, "R1 R10 R9");
    endtask

    task automatic t_single();     // R5 one-sample line: every tap reads sample 0
        fill(6, 0);
        do_pass(1, 4, 4096, 1'b0, '1, 1'b0, "R5 single");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_identity();
        t_downscale();
        t_upscale();
        t_color();
        t_stray();
        t_single();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule